// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an addressing-mode code, the operand bytes of an instruction, the index registers, the stack pointer and any pointer bytes already fetched into every address an 8-bit accumulator CPU with a 16-bit address bus needs for one operand access. It gives the two addresses from which an indirect pointer is read, the final effective address, a page-cross indicator, the number of extra cycles the access costs and the stack pointer value after a push or pull.

Some modes wrap inside one 256-byte page instead of carrying into the high byte, and the unit reproduces each of these cases exactly: zero-page indexing, the zero-page pointer pair of the two indirect modes, and the pointer pair of the indirect jump. The sequencer that owns the instruction presents the mode and operands, and it presents the pointer bytes read from the addresses the unit reported. Results appear one clock later when the output stage is registered (`REG_OUT=1`, the default).

Top module: `eau_top`

## Requirements
- R1: Mode 0 (zero page) gives address {00,op_lo}. Mode 1 adds X and mode 2 adds Y to op_lo modulo 256, so the high byte of the address is always 00 (op_lo=FF with X=01 gives 0000).
- R2: Mode 6 (pre-indexed indirect) reads its pointer low byte from {00, op_lo+X mod 256} and its high byte from the next zero-page byte, wrapping inside the page (FF is followed by 0000). The effective address is {ptr_hi,ptr_lo}.
- R3: Mode 7 (post-indexed indirect) reads its pointer from {00,op_lo} and {00,op_lo+1 mod 256}. The effective address is {ptr_hi,ptr_lo}+Y with a full 16-bit carry, and page_cross is 1 when that carry changes the high byte.
- R4: Mode 8 (indirect jump) reads its pointer from {op_hi,op_lo} and {op_hi,op_lo+1 mod 256}, which keeps the high byte in the same page (12FF is followed by 1200). The effective address is {ptr_hi,ptr_lo}.
- R5: Mode 3 gives {op_hi,op_lo}. Modes 4 and 5 add X and Y respectively with a full 16-bit carry, and page_cross is 1 exactly when the high byte changes.
- R6: For modes 4, 5 and 7, extra_cyc is 1 when rmw_store is 1, whatever the page. Otherwise extra_cyc equals page_cross. All other non-branch modes give extra_cyc 0.
- R7: Mode 9 (relative) gives next_pc plus op_lo read as a signed 8-bit value, and page_cross is 1 when the target page differs from the page of next_pc. extra_cyc is 0 when br_taken is 0, 1 when the branch is taken within the same page, and 2 when it is taken across a page.
- R8: Mode 10 (push) gives address {01,sp} and sp_next=sp-1. Mode 11 (pull) gives {01,sp+1} and sp_next=sp+1, both modulo 256. Every other mode gives sp_next=sp.
- R9: Modes 12, 13 and 14 read a vector pointer from FFFA/FFFB, FFFC/FFFD and FFFE/FFFF respectively (interrupt, reset, break). The effective address is {ptr_hi,ptr_lo}.
- R10: With REG_OUT=1 every output shows the inputs of the previous clock edge. out_valid equals in_valid, except that mode 15 (no operand) gives 0.
- R11: Reset clears every output to zero. Whenever out_valid is 0, page_cross and extra_cyc are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing-mode code (see requirements) |
| rmw_store | input | 1 | Access is a store or read-modify-write |
| br_taken | input | 1 | Branch condition is true (mode 9) |
| op_lo | input | 8 | First operand byte / branch offset |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| sp | input | 8 | Stack pointer |
| ptr_lo | input | 8 | Pointer low byte read from ptr_lo_addr |
| ptr_hi | input | 8 | Pointer high byte read from ptr_hi_addr |
| next_pc | input | 16 | Address of the following instruction |
| out_valid | output | 1 | Results are meaningful |
| ptr_lo_addr | output | 16 | Address of the pointer low byte |
| ptr_hi_addr | output | 16 | Address of the pointer high byte |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Indexing or branch changed the page |
| extra_cyc | output | 2 | Extra cycles the access costs |
| sp_next | output | 8 | Stack pointer after the access |

## Verification
The assertions assume a stable mode code and that reset is held for at least one edge before the first request. They also assume the pointer bytes belong to the addresses the unit reports within the same request. Their page and wrap properties are stated only in terms of the outputs, so they hold for any operand values. The directed stimulus drives a complete, consistent set of inputs once per request at the falling edge. It chooses operands at FF/00 boundaries and at page edges, and it drives each request only for the mode codes listed above.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef enum logic [3:0] {
    M_ZP   = 4'd0,  M_ZPX  = 4'd1,  M_ZPY  = 4'd2,  M_ABS  = 4'd3,
    M_ABSX = 4'd4,  M_ABSY = 4'd5,  M_INDX = 4'd6,  M_INDY = 4'd7,
    M_IND  = 4'd8,  M_REL  = 4'd9,  M_PUSH = 4'd10, M_PULL = 4'd11,
    M_VNMI = 4'd12, M_VRST = 4'd13, M_VIRQ = 4'd14, M_NONE = 4'd15
  } mode_e;

  localparam logic [DW-1:0] STACK_PAGE = 8'h01;
  localparam logic [AW-1:0] VEC_NMI    = 16'hFFFA;
  localparam logic [AW-1:0] VEC_RST    = 16'hFFFC;
  localparam logic [AW-1:0] VEC_IRQ    = 16'hFFFE;
endpackage

// File: rtl/eau_idx_add.sv
// Adds an 8-bit index to a base address, either wrapping in the page
// or carrying into the high byte; optionally sign-extends the index.
module eau_idx_add #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] idx,
  input  logic          wrap_page,
  input  logic          signed_idx,
  output logic [AW-1:0] sum,
  output logic          crossed
);
  localparam int HW = AW - DW;
  logic [AW-1:0] ext;
  logic [AW-1:0] full;
  logic [DW-1:0] low;

  always_comb begin
    ext     = signed_idx ? {{HW{idx[DW-1]}}, idx} : {{HW{1'b0}}, idx};
    full    = base + ext;
    low     = base[DW-1:0] + idx;
    sum     = wrap_page ? {base[AW-1:DW], low} : full;
    crossed = !wrap_page && (full[AW-1:DW] != base[AW-1:DW]);
  end
endmodule

// File: rtl/eau_cycle_calc.sv
// Extra-cycle count from mode, crossing and store/branch qualifiers.
module eau_cycle_calc
  import eau_pkg::*;
(
  input  logic       valid,
  input  mode_e      mode,
  input  logic       crossed,
  input  logic       rmw_store,
  input  logic       br_taken,
  output logic [1:0] extra
);
  always_comb begin
    extra = 2'd0;
    if (valid) begin
      unique case (mode)
        M_ABSX, M_ABSY, M_INDY: extra = (rmw_store || crossed) ? 2'd1 : 2'd0;
        M_REL: begin
          if (br_taken) extra = crossed ? 2'd2 : 2'd1;
        end
        default: extra = 2'd0;
      endcase
    end
  end
endmodule

// File: rtl/eau_top.sv
module eau_top
  import eau_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    mode,
  input  logic          rmw_store,
  input  logic          br_taken,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] op_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] ptr_lo,
  input  logic [DW-1:0] ptr_hi,
  input  logic [AW-1:0] next_pc,
  output logic          out_valid,
  output logic [AW-1:0] ptr_lo_addr,
  output logic [AW-1:0] ptr_hi_addr,
  output logic [AW-1:0] ea,
  output logic          page_cross,
  output logic [1:0]    extra_cyc,
  output logic [DW-1:0] sp_next
);
  localparam logic [DW-1:0] ZPAGE = '0;

  mode_e mode_c;
  assign mode_c = mode_e'(mode);

  // data-path adder selection
  logic [AW-1:0] d_base;
  logic [DW-1:0] d_idx;
  logic          d_wrap, d_signed;
  logic [AW-1:0] d_sum;
  logic          d_cross;

  always_comb begin
    d_base   = {op_hi, op_lo};
    d_idx    = '0;
    d_wrap   = 1'b0;
    d_signed = 1'b0;
    unique case (mode_c)
      M_ZP:   begin d_base = {ZPAGE, op_lo}; d_wrap = 1'b1; end
      M_ZPX:  begin d_base = {ZPAGE, op_lo}; d_idx = idx_x; d_wrap = 1'b1; end
      M_ZPY:  begin d_base = {ZPAGE, op_lo}; d_idx = idx_y; d_wrap = 1'b1; end
      M_ABSX: d_idx = idx_x;
      M_ABSY: d_idx = idx_y;
      M_INDY: begin d_base = {ptr_hi, ptr_lo}; d_idx = idx_y; end
      M_REL:  begin d_base = next_pc; d_idx = op_lo; d_signed = 1'b1; end
      default: ;
    endcase
  end

  eau_idx_add #(.AW(AW), .DW(DW)) u_data_add (
    .base(d_base), .idx(d_idx), .wrap_page(d_wrap), .signed_idx(d_signed),
    .sum(d_sum), .crossed(d_cross)
  );

  // zero-page pointer for the pre-indexed mode
  logic [AW-1:0] zp_ptr;
  logic          zp_ptr_cross;
  eau_idx_add #(.AW(AW), .DW(DW)) u_zp_ptr (
    .base({ZPAGE, op_lo}), .idx(idx_x), .wrap_page(1'b1), .signed_idx(1'b0),
    .sum(zp_ptr), .crossed(zp_ptr_cross)
  );

  // pointer low-byte address and use flag
  logic [AW-1:0] plo_c;
  logic          use_ptr;
  always_comb begin
    plo_c   = '0;
    use_ptr = 1'b1;
    unique case (mode_c)
      M_INDX: plo_c = zp_ptr;
      M_INDY: plo_c = {ZPAGE, op_lo};
      M_IND:  plo_c = {op_hi, op_lo};
      M_VNMI: plo_c = VEC_NMI;
      M_VRST: plo_c = VEC_RST;
      M_VIRQ: plo_c = VEC_IRQ;
      default: use_ptr = 1'b0;
    endcase
  end

  // high byte always follows inside the same page
  logic [AW-1:0] phi_sum;
  logic          phi_cross;
  eau_idx_add #(.AW(AW), .DW(DW)) u_ptr_next (
    .base(plo_c), .idx(8'd1), .wrap_page(1'b1), .signed_idx(1'b0),
    .sum(phi_sum), .crossed(phi_cross)
  );

  // final address, crossing and stack pointer
  logic          vld_c;
  logic [AW-1:0] ea_c, phi_c;
  logic          cross_c;
  logic [DW-1:0] spn_c;
  always_comb begin
    vld_c   = in_valid && (mode_c != M_NONE);
    phi_c   = use_ptr ? phi_sum : '0;
    ea_c    = d_sum;
    cross_c = d_cross;
    spn_c   = sp;
    unique case (mode_c)
      M_INDX, M_IND, M_VNMI, M_VRST, M_VIRQ: begin
        ea_c = {ptr_hi, ptr_lo}; cross_c = 1'b0;
      end
      M_PUSH: begin
        ea_c = {STACK_PAGE, sp}; spn_c = sp - 8'd1; cross_c = 1'b0;
      end
      M_PULL: begin
        spn_c = sp + 8'd1; ea_c = {STACK_PAGE, spn_c}; cross_c = 1'b0;
      end
      M_NONE: begin ea_c = '0; cross_c = 1'b0; end
      default: ;
    endcase
    if (!vld_c) cross_c = 1'b0;
  end

  logic [1:0] extra_c;
  eau_cycle_calc u_cyc (
    .valid(vld_c), .mode(mode_c), .crossed(cross_c),
    .rmw_store(rmw_store), .br_taken(br_taken), .extra(extra_c)
  );

  mode_e mode_q;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid   <= 1'b0;
          ptr_lo_addr <= '0;
          ptr_hi_addr <= '0;
          ea          <= '0;
          page_cross  <= 1'b0;
          extra_cyc   <= 2'd0;
          sp_next     <= '0;
          mode_q      <= M_NONE;
        end else begin
          out_valid   <= vld_c;
          ptr_lo_addr <= plo_c;
          ptr_hi_addr <= phi_c;
          ea          <= ea_c;
          page_cross  <= cross_c;
          extra_cyc   <= extra_c;
          sp_next     <= spn_c;
          mode_q      <= mode_c;
        end
      end
    end else begin : g_comb
      always_comb begin
        out_valid   = vld_c;
        ptr_lo_addr = plo_c;
        ptr_hi_addr = phi_c;
        ea          = ea_c;
        page_cross  = cross_c;
        extra_cyc   = extra_c;
        sp_next     = spn_c;
        mode_q      = mode_c;
      end
    end
  endgenerate

endmodule

// File: rtl/eau_checker.sv
module eau_checker
  import eau_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input mode_e         mode_q,
  input logic [AW-1:0] ptr_lo_addr,
  input logic [AW-1:0] ptr_hi_addr,
  input logic [AW-1:0] ea,
  input logic          page_cross,
  input logic [1:0]    extra_cyc
);
  // R1: zero-page modes never leave page zero
  assert_zp_page_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (mode_q == M_ZP || mode_q == M_ZPX || mode_q == M_ZPY))
      |-> (ea[AW-1:DW] == '0));

  // R2 / R3: zero-page pointer pair stays in page zero and wraps
  assert_zp_ptr_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (mode_q == M_INDX || mode_q == M_INDY))
      |-> (ptr_hi_addr[AW-1:DW] == '0 && ptr_lo_addr[AW-1:DW] == '0 &&
           ptr_hi_addr[DW-1:0] == ptr_lo_addr[DW-1:0] + 8'd1));

  // R4: indirect-jump pointer high byte in the same page
  assert_ind_same_page_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == M_IND)
      |-> (ptr_hi_addr[AW-1:DW] == ptr_lo_addr[AW-1:DW]));

  // R8: stack accesses in the stack page
  assert_stack_page_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (mode_q == M_PUSH || mode_q == M_PULL))
      |-> (ea[AW-1:DW] == STACK_PAGE));

  // R7: two extra cycles only for a crossing branch
  assert_two_extra_R7: assert property (@(posedge clk) disable iff (rst)
    (extra_cyc == 2'd2) |-> (page_cross && mode_q == M_REL));

  // R11: nothing reported without a valid result
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!page_cross && extra_cyc == 2'd0));
endmodule

bind eau_top eau_checker u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .mode_q(mode_q),
  .ptr_lo_addr(ptr_lo_addr), .ptr_hi_addr(ptr_hi_addr), .ea(ea),
  .page_cross(page_cross), .extra_cyc(extra_cyc)
);

// File: tb/sim_eau_top.sv
module sim_eau_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  mode = 4'd15;
  logic        rmw_store = 1'b0, br_taken = 1'b0;
  logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0, sp = '0;
  logic [7:0]  ptr_lo = '0, ptr_hi = '0;
  logic [15:0] next_pc = '0;
  logic        out_valid, page_cross;
  logic [15:0] ptr_lo_addr, ptr_hi_addr, ea;
  logic [1:0]  extra_cyc;
  logic [7:0]  sp_next;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  eau_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .rmw_store(rmw_store), .br_taken(br_taken), .op_lo(op_lo), .op_hi(op_hi),
    .idx_x(idx_x), .idx_y(idx_y), .sp(sp), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
    .next_pc(next_pc), .out_valid(out_valid), .ptr_lo_addr(ptr_lo_addr),
    .ptr_hi_addr(ptr_hi_addr), .ea(ea), .page_cross(page_cross),
    .extra_cyc(extra_cyc), .sp_next(sp_next)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one request at the falling edge, sample one cycle later
  task automatic issue(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] x, input logic [7:0] y, input logic [7:0] s,
                       input logic [7:0] plo, input logic [7:0] phi,
                       input logic rmw, input logic tk, input logic [15:0] pc);
    @(negedge clk);
    in_valid = 1'b1; mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y;
    sp = s; ptr_lo = plo; ptr_hi = phi; rmw_store = rmw; br_taken = tk; next_pc = pc;
    @(negedge clk);
    in_valid = 1'b0; mode = 4'd15;
  endtask

  task automatic t_reset();
    chk("R11 reset valid", out_valid, 0);
    chk("R11 reset ea", ea, 0);
    chk("R11 reset extra", extra_cyc, 0);
    chk("R11 reset sp_next", sp_next, 0);
  endtask

  task automatic t_zero_page();
    issue(4'd0, 8'h42, 8'h99, 8'h00, 8'h00, 8'h10, 0, 0, 0, 0, 16'h0);
    chk("R1 zp", ea, 16'h0042);
    chk("R10 valid", out_valid, 1);
    issue(4'd1, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h10, 0, 0, 0, 0, 16'h0);
    chk("R1 zpx wrap", ea, 16'h0000);
    chk("R1 zpx no cross", page_cross, 0);
    issue(4'd2, 8'h80, 8'h00, 8'h00, 8'h90, 8'h10, 0, 0, 0, 0, 16'h0);
    chk("R1 zpy wrap", ea, 16'h0010);
    chk("R8 sp unchanged", sp_next, 8'h10);
  endtask

  task automatic t_absolute();
    issue(4'd3, 8'h34, 8'h12, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 16'h0);
    chk("R5 abs", ea, 16'h1234);
    issue(4'd4, 8'hF0, 8'h12, 8'h20, 8'h00, 8'h00, 0, 0, 0, 0, 16'h0);
    chk("R5 absx carry", ea, 16'h1310);
    chk("R5 absx cross", page_cross, 1);
    chk("R6 read cross extra", extra_cyc, 1);
    issue(4'd5, 8'h00, 8'h12, 8'h00, 8'h05, 8'h00, 0, 0, 0, 0, 16'h0);
    chk("R5 absy", ea, 16'h1205);
    chk("R6 read no cross extra", extra_cyc, 0);
    issue(4'd4, 8'h00, 8'h12, 8'h05, 8'h00, 8'h00, 0, 0, 1, 0, 16'h0);
    chk("R6 store forced extra", extra_cyc, 1);
    chk("R5 store no cross", page_cross, 0);
  endtask

  task automatic t_indirect();
    issue(4'd6, 8'hFE, 8'h00, 8'h01, 8'h00, 8'h00, 8'h78, 8'h56, 0, 0, 16'h0);
    chk("R2 indx lo addr", ptr_lo_addr, 16'h00FF);
    chk("R2 indx hi addr wrap", ptr_hi_addr, 16'h0000);
    chk("R2 indx ea", ea, 16'h5678);
    issue(4'd7, 8'hFF, 8'h00, 8'h00, 8'h20, 8'h00, 8'hF0, 8'h12, 0, 0, 16'h0);
    chk("R3 indy lo addr", ptr_lo_addr, 16'h00FF);
    chk("R3 indy hi addr wrap", ptr_hi_addr, 16'h0000);
    chk("R3 indy ea", ea, 16'h1310);
    chk("R3 indy cross", page_cross, 1);
    chk("R6 indy extra", extra_cyc, 1);
    issue(4'd7, 8'h10, 8'h00, 8'h00, 8'h01, 8'h00, 8'hF0, 8'h12, 1, 0, 16'h0);
    chk("R3 indy no cross", page_cross, 0);
    chk("R6 indy store extra", extra_cyc, 1);
    issue(4'd8, 8'hFF, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 0, 0, 16'h0);
    chk("R4 ind lo addr", ptr_lo_addr, 16'h12FF);
    chk("R4 ind hi addr", ptr_hi_addr, 16'h1200);
    chk("R4 ind ea", ea, 16'h8000);
  endtask

  task automatic t_branch();
    issue(4'd9, 8'h20, 8'h00, 0, 0, 0, 0, 0, 0, 1, 16'h10F0);
    chk("R7 fwd target", ea, 16'h1110);
    chk("R7 taken cross extra", extra_cyc, 2);
    issue(4'd9, 8'hF0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 16'h10F0);
    chk("R7 back target", ea, 16'h10E0);
    chk("R7 taken same extra", extra_cyc, 1);
    chk("R7 same no cross", page_cross, 0);
    issue(4'd9, 8'h20, 8'h00, 0, 0, 0, 0, 0, 0, 0, 16'h10F0);
    chk("R7 not taken extra", extra_cyc, 0);
    issue(4'd9, 8'h80, 8'h00, 0, 0, 0, 0, 0, 0, 1, 16'h1000);
    chk("R7 min offset", ea, 16'h0F80);
    chk("R7 min offset extra", extra_cyc, 2);
  endtask

  task automatic t_stack();
    issue(4'd10, 0, 0, 0, 0, 8'h00, 0, 0, 0, 0, 16'h0);
    chk("R8 push addr", ea, 16'h0100);
    chk("R8 push sp", sp_next, 8'hFF);
    issue(4'd11, 0, 0, 0, 0, 8'hFF, 0, 0, 0, 0, 16'h0);
    chk("R8 pull addr", ea, 16'h0100);
    chk("R8 pull sp", sp_next, 8'h00);
    issue(4'd11, 0, 0, 0, 0, 8'hF3, 0, 0, 0, 0, 16'h0);
    chk("R8 pull addr2", ea, 16'h01F4);
  endtask

  task automatic t_vectors();
    issue(4'd12, 0, 0, 0, 0, 0, 8'h11, 8'h22, 0, 0, 16'h0);
    chk("R9 nmi lo", ptr_lo_addr, 16'hFFFA);
    chk("R9 nmi hi", ptr_hi_addr, 16'hFFFB);
    chk("R9 nmi ea", ea, 16'h2211);
    issue(4'd13, 0, 0, 0, 0, 0, 8'h00, 8'hC0, 0, 0, 16'h0);
    chk("R9 rst lo", ptr_lo_addr, 16'hFFFC);
    chk("R9 rst ea", ea, 16'hC000);
    issue(4'd14, 0, 0, 0, 0, 0, 8'h00, 8'hE0, 0, 0, 16'h0);
    chk("R9 irq hi", ptr_hi_addr, 16'hFFFF);
  endtask

  task automatic t_idle();
    issue(4'd15, 0, 0, 0, 0, 8'h33, 0, 0, 1, 1, 16'h0);
    chk("R10 none invalid", out_valid, 0);
    chk("R11 none extra", extra_cyc, 0);
    chk("R11 none cross", page_cross, 0);
    // in_valid low with a crossing request: no result reported
    @(negedge clk);
    in_valid = 1'b0; mode = 4'd4; op_lo = 8'hFF; op_hi = 8'h12; idx_x = 8'h01; rmw_store = 1'b0;
    @(negedge clk);
    chk("R10 idle invalid", out_valid, 0);
    chk("R11 idle cross", page_cross, 0);
    chk("R11 idle extra", extra_cyc, 0);
    mode = 4'd15;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_zero_page();
    t_absolute();
    t_indirect();
    t_branch();
    t_stack();
    t_vectors();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule